// File: doc/BRIEF.md
# Split Data/Address Register File

This block is the architectural register store of a 32-bit CISC core. It holds two classes of general registers, eight data registers and eight address registers, along with a shadow stack pointer. It serves two combinational read ports and one synchronous write port. Each port names a register class, an index and an operand size. Data and address registers handle partial widths differently. Data registers keep their untouched upper bits on a narrow write and zero-fill on a narrow read. Address registers sign-extend to the full 32 bits in both directions.

Address register 7 is the active stack pointer. When the supervisor-mode input changes level, the stack pointer trades places with the shadow register. A built-in sequencer performs multi-register loads. It takes a 16-bit selection mask, a start address and a size. It walks the selected registers one per cycle, presents the memory address for each one, and stores the word returned on the load data input. Instruction decode, address generation and the memory bus belong to the surrounding core.

Top module: `split_regfile`

## Requirements
- R1: A data-register write (class 0) of byte size (0) or word size (1) replaces only bits 7:0 or 15:0. All other bits keep their previous value.
- R2: A data-register read of byte or word size returns bits 7:0 or 15:0 with every higher bit zero.
- R3: An address-register write (class 1) of byte or word size stores bit 7 or bit 15 copied into all higher bits.
- R4: An address-register read of byte or word size returns the low 8 or 16 bits sign-extended to 32 bits.
- R5: Long size (2), and size code 3 as well, writes and reads all 32 bits unchanged for both classes.
- R6: Each rising or falling change of `super_mode` exchanges the contents of address register 7 and the shadow stack pointer. The level seen while reset is active never causes an exchange.
- R7: While `rst_n` is low at a clock edge, all data registers, all address registers and the shadow pointer are cleared to zero, and the load sequencer becomes idle.
- R8: A load started with a nonzero mask serves one selected register per cycle. The order is data registers 0..7 (mask bits 0..7) and then address registers 0..7 (mask bits 8..15). `ml_addr` starts at `ml_base` and advances by 4 per register for long sizes and by 2 otherwise. A zero mask starts nothing.
- R9: A read of the register being written in the same cycle returns the value it held before that clock edge.
- R10: While `ml_busy` is high, the write port and `ml_start` have no effect.
- R11: A port write to address register 7 in the same cycle as a mode change wins for register 7. The shadow pointer receives the pre-edge value of register 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd0_cls | input | 1 | Read port 0 class: 0 data, 1 address |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size: 0 byte, 1 word, 2/3 long |
| rd0_data | output | 32 | Read port 0 formatted value |
| rd1_cls | input | 1 | Read port 1 class |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size |
| rd1_data | output | 32 | Read port 1 formatted value |
| wr_en | input | 1 | Write port enable |
| wr_cls | input | 1 | Write port class |
| wr_idx | input | 3 | Write port register index |
| wr_size | input | 2 | Write port size |
| wr_data | input | 32 | Write port value |
| super_mode | input | 1 | Supervisor level; a change swaps the stack pointers |
| ml_start | input | 1 | Begin a multi-register load |
| ml_mask | input | 16 | Load selection: bits 0..7 data, 8..15 address |
| ml_base | input | 32 | First load address |
| ml_size | input | 2 | Load element size |
| ml_rdata | input | 32 | Data returned for the current load address |
| ml_busy | output | 1 | Load sequence in progress |
| ml_addr | output | 32 | Memory address of the current load element |

## Verification
Reads are combinational, so a read result is due in the same cycle as its select inputs. A written value, a swap or a reset appears on the read ports right after the one clock edge that stores it. A load started at one edge raises `ml_busy` and shows `ml_base` after that edge. The word on `ml_rdata` during each busy cycle lands in its register at the following edge. The bench drives every input and samples every output one nanosecond after a rising edge. It checks the pre-edge value for same-cycle read/write cases and the post-edge value for each stored result, stepping exactly one edge per load element.

// File: rtl/regfile_pkg.sv
// Shared encodings for the split register file.
// Assumes the size code is two bits and the class code is one bit.
package regfile_pkg;
    localparam logic CLS_DATA = 1'b0;
    localparam logic CLS_ADDR = 1'b1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } size_e;

    // Long when the upper size bit is set (codes 2 and 3).
    function automatic logic size_is_long(input logic [1:0] sz);
        return sz[1];
    endfunction
endpackage

// File: rtl/rf_read_fmt.sv
// Formats a stored register for a read port.
// Data class zero-extends narrow reads; address class sign-extends them.
// Assumes DATA_W >= 16.
module rf_read_fmt #(
    parameter int DATA_W = 32
) (
    input  logic              cls,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] val
);
    import regfile_pkg::*;

    // Pick the width and the fill bit for the requested size.
    always_comb begin
        val = raw;
        if (!size_is_long(size)) begin
            if (size == SZ_BYTE)
                val = {{(DATA_W-8){(cls == CLS_ADDR) & raw[7]}}, raw[7:0]};
            else
                val = {{(DATA_W-16){(cls == CLS_ADDR) & raw[15]}}, raw[15:0]};
        end
    end
endmodule

// File: rtl/rf_write_fmt.sv
// Builds the value stored by a write of a given class and size.
// Data class merges narrow data into the old value; address class sign-extends.
// Assumes DATA_W >= 16.
module rf_write_fmt #(
    parameter int DATA_W = 32
) (
    input  logic              cls,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] store_val
);
    import regfile_pkg::*;

    // Merge or extend according to class and size.
    always_comb begin
        store_val = new_val;
        if (!size_is_long(size)) begin
            if (size == SZ_BYTE)
                store_val = (cls == CLS_ADDR) ? {{(DATA_W-8){new_val[7]}}, new_val[7:0]}
                                              : {old_val[DATA_W-1:8], new_val[7:0]};
            else
                store_val = (cls == CLS_ADDR) ? {{(DATA_W-16){new_val[15]}}, new_val[15:0]}
                                              : {old_val[DATA_W-1:16], new_val[15:0]};
        end
    end
endmodule

// File: rtl/rf_load_seq.sv
// Multi-register load sequencer: latches a selection mask, then serves the
// lowest pending bit each cycle while stepping the memory address.
// Assumes NREG is a power of two; mask bits [NREG-1:0] are data registers,
// the upper half address registers. A start while busy is ignored.
module rf_load_seq #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2*NREG-1:0]       mask,
    input  logic [DATA_W-1:0]       base,
    input  logic [1:0]              size,
    output logic                    busy,
    output logic [DATA_W-1:0]       addr,
    output logic                    tgt_cls,
    output logic [$clog2(NREG)-1:0] tgt_idx,
    output logic [1:0]              size_q
);
    import regfile_pkg::*;

    localparam int MW    = 2 * NREG;
    localparam int SEL_W = $clog2(MW);

    logic [MW-1:0]     pend_q;
    logic [DATA_W-1:0] addr_q;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] step;

    // Find the lowest pending selection bit.
    always_comb begin
        sel = '0;
        for (int i = MW - 1; i >= 0; i--)
            if (pend_q[i]) sel = SEL_W'(i);
    end

    assign busy    = |pend_q;
    assign addr    = addr_q;
    assign tgt_cls = sel[SEL_W-1];
    assign tgt_idx = sel[SEL_W-2:0];
    assign step    = size_is_long(size_q) ? DATA_W'(4) : DATA_W'(2);

    // Accept a new load when idle, otherwise retire one element per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            addr_q <= '0;
            size_q <= '0;
        end else if (!busy) begin
            if (start) begin
                pend_q <= mask;
                addr_q <= base;
                size_q <= size;
            end
        end else begin
            pend_q[sel] <= 1'b0;
            addr_q      <= addr_q + step;
        end
    end
endmodule

// File: rtl/split_regfile.sv
// Split data/address register file with two read ports, one write port,
// a stack-pointer/shadow exchange on supervisor changes and a
// multi-register load sequencer. Reads are combinational and return the
// pre-edge contents; the sequencer owns the write path while busy.
module split_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG),
    localparam int MW    = 2 * NREG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd0_cls,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [1:0]        rd0_size,
    output logic [DATA_W-1:0] rd0_data,
    input  logic              rd1_cls,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [1:0]        rd1_size,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic              wr_cls,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              super_mode,
    input  logic              ml_start,
    input  logic [MW-1:0]     ml_mask,
    input  logic [DATA_W-1:0] ml_base,
    input  logic [1:0]        ml_size,
    input  logic [DATA_W-1:0] ml_rdata,
    output logic              ml_busy,
    output logic [DATA_W-1:0] ml_addr
);
    import regfile_pkg::*;

    localparam int SP = NREG - 1;

    logic [DATA_W-1:0] dreg_q [NREG];
    logic [DATA_W-1:0] areg_q [NREG];
    logic [DATA_W-1:0] shadow_q;
    logic              prev_super_q;

    logic              seq_cls;
    logic [IDX_W-1:0]  seq_idx;
    logic [1:0]        seq_size;

    logic              w_en, w_cls;
    logic [IDX_W-1:0]  w_idx;
    logic [1:0]        w_size;
    logic [DATA_W-1:0] w_data, w_old, w_store;
    logic              swap;

    rf_load_seq #(.DATA_W(DATA_W), .NREG(NREG)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ml_start),
        .mask   (ml_mask),
        .base   (ml_base),
        .size   (ml_size),
        .busy   (ml_busy),
        .addr   (ml_addr),
        .tgt_cls(seq_cls),
        .tgt_idx(seq_idx),
        .size_q (seq_size)
    );

    // Gather read-port selects so both ports share one generated formatter.
    logic              r_cls  [2];
    logic [IDX_W-1:0]  r_idx  [2];
    logic [1:0]        r_size [2];
    logic [DATA_W-1:0] r_out  [2];

    assign r_cls[0]  = rd0_cls;   assign r_cls[1]  = rd1_cls;
    assign r_idx[0]  = rd0_idx;   assign r_idx[1]  = rd1_idx;
    assign r_size[0] = rd0_size;  assign r_size[1] = rd1_size;
    assign rd0_data  = r_out[0];
    assign rd1_data  = r_out[1];

    for (genvar p = 0; p < 2; p++) begin : g_rport
        logic [DATA_W-1:0] raw;
        assign raw = (r_cls[p] == CLS_ADDR) ? areg_q[r_idx[p]] : dreg_q[r_idx[p]];
        rf_read_fmt #(.DATA_W(DATA_W)) fmt_i (
            .cls (r_cls[p]),
            .size(r_size[p]),
            .raw (raw),
            .val (r_out[p])
        );
    end

    // Select the write source: the sequencer while busy, else the write port.
    always_comb begin
        w_en   = ml_busy | wr_en;
        w_cls  = ml_busy ? seq_cls  : wr_cls;
        w_idx  = ml_busy ? seq_idx  : wr_idx;
        w_size = ml_busy ? seq_size : wr_size;
        w_data = ml_busy ? ml_rdata : wr_data;
        w_old  = (w_cls == CLS_ADDR) ? areg_q[w_idx] : dreg_q[w_idx];
    end

    rf_write_fmt #(.DATA_W(DATA_W)) wfmt_i (
        .cls      (w_cls),
        .size     (w_size),
        .old_val  (w_old),
        .new_val  (w_data),
        .store_val(w_store)
    );

    assign swap = super_mode ^ prev_super_q;

    // Register update: reset, writes, and the stack-pointer exchange.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                dreg_q[i] <= '0;
                areg_q[i] <= '0;
            end
            shadow_q     <= '0;
            prev_super_q <= super_mode;
        end else begin
            prev_super_q <= super_mode;
            for (int i = 0; i < NREG; i++) begin
                if (w_en && w_cls == CLS_DATA && w_idx == IDX_W'(i))
                    dreg_q[i] <= w_store;
                if (w_en && w_cls == CLS_ADDR && w_idx == IDX_W'(i))
                    areg_q[i] <= w_store;
                else if (i == SP && swap)
                    areg_q[i] <= shadow_q;
            end
            if (swap) shadow_q <= areg_q[SP];
        end
    end
endmodule

// File: rtl/split_regfile_chk.sv
// Property checker for split_regfile, attached by bind below.
// Observes ports only.
module split_regfile_chk #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd0_cls,
    input logic [1:0]        rd0_size,
    input logic [DATA_W-1:0] rd0_data,
    input logic              rd1_cls,
    input logic [1:0]        rd1_size,
    input logic [DATA_W-1:0] rd1_data,
    input logic              ml_start,
    input logic [2*NREG-1:0] ml_mask,
    input logic [DATA_W-1:0] ml_base,
    input logic              ml_busy,
    input logic [DATA_W-1:0] ml_addr
);
    p_data_byte_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_cls == 1'b0 && rd0_size == 2'd0) |-> rd0_data[DATA_W-1:8] == '0);

    p_addr_word_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_cls == 1'b1 && rd1_size == 2'd1) |-> rd1_data[DATA_W-1:16] == {(DATA_W-16){rd1_data[15]}});

    p_reset_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd0_data == '0 && rd1_data == '0 && !ml_busy));

    p_load_first_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ml_busy && ml_start && ml_mask != '0) |=> (ml_busy && ml_addr == $past(ml_base)));

    p_load_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ml_busy && $past(ml_busy)) |-> (ml_addr - $past(ml_addr) == DATA_W'(4) ||
                                         ml_addr - $past(ml_addr) == DATA_W'(2)));

    p_empty_mask_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ml_busy && ml_start && ml_mask == '0) |=> !ml_busy);

    p_busy_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ml_busy && ml_start) |=> (!ml_busy || ml_addr != $past(ml_base) || ml_addr == $past(ml_addr) + DATA_W'(4) || ml_addr == $past(ml_addr) + DATA_W'(2)));
endmodule

bind split_regfile split_regfile_chk #(.DATA_W(DATA_W), .NREG(NREG)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd0_cls (rd0_cls),
    .rd0_size(rd0_size),
    .rd0_data(rd0_data),
    .rd1_cls (rd1_cls),
    .rd1_size(rd1_size),
    .rd1_data(rd1_data),
    .ml_start(ml_start),
    .ml_mask (ml_mask),
    .ml_base (ml_base),
    .ml_busy (ml_busy),
    .ml_addr (ml_addr)
);

// File: tb/split_regfile_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table for size/class behaviour, then
// directed tests for swap, load sequencing, hazards and reset.
module split_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd0_cls = 0, rd1_cls = 0;
    logic [2:0]  rd0_idx = 0, rd1_idx = 0;
    logic [1:0]  rd0_size = 2, rd1_size = 2;
    logic [31:0] rd0_data, rd1_data;
    logic        wr_en = 0, wr_cls = 0;
    logic [2:0]  wr_idx = 0;
    logic [1:0]  wr_size = 2;
    logic [31:0] wr_data = 0;
    logic        super_mode = 0;
    logic        ml_start = 0;
    logic [15:0] ml_mask = 0;
    logic [31:0] ml_base = 0;
    logic [1:0]  ml_size = 2;
    logic [31:0] ml_rdata = 0;
    logic        ml_busy;
    logic [31:0] ml_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    split_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd0_cls(rd0_cls), .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
        .rd1_cls(rd1_cls), .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_cls(wr_cls), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
        .super_mode(super_mode),
        .ml_start(ml_start), .ml_mask(ml_mask), .ml_base(ml_base), .ml_size(ml_size),
        .ml_rdata(ml_rdata), .ml_busy(ml_busy), .ml_addr(ml_addr)
    );

    typedef struct packed {
        logic        wen;
        logic        wcls;
        logic [2:0]  widx;
        logic [1:0]  wsz;
        logic [31:0] wdat;
        logic        rcls;
        logic [2:0]  ridx;
        logic [1:0]  rsz;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 3'd0, 2'd2, 32'h12345678, 1'b0, 3'd0, 2'd2, 32'h12345678}, // R5
        '{1'b1, 1'b0, 3'd0, 2'd0, 32'hFFFFFFAB, 1'b0, 3'd0, 2'd2, 32'h123456AB}, // R1
        '{1'b1, 1'b0, 3'd0, 2'd1, 32'h0000CDEF, 1'b0, 3'd0, 2'd2, 32'h1234CDEF}, // R1
        '{1'b1, 1'b0, 3'd1, 2'd3, 32'hCAFEF00D, 1'b0, 3'd1, 2'd2, 32'hCAFEF00D}, // R5
        '{1'b1, 1'b0, 3'd2, 2'd2, 32'h89ABCDEF, 1'b0, 3'd2, 2'd0, 32'h000000EF}, // R2
        '{1'b0, 1'b0, 3'd0, 2'd2, 32'h00000000, 1'b0, 3'd2, 2'd1, 32'h0000CDEF}, // R2
        '{1'b1, 1'b1, 3'd0, 2'd0, 32'h00000080, 1'b1, 3'd0, 2'd2, 32'hFFFFFF80}, // R3
        '{1'b1, 1'b1, 3'd1, 2'd1, 32'h00007FFF, 1'b1, 3'd1, 2'd2, 32'h00007FFF}, // R3
        '{1'b1, 1'b1, 3'd2, 2'd1, 32'h12348000, 1'b1, 3'd2, 2'd2, 32'hFFFF8000}, // R3
        '{1'b1, 1'b1, 3'd3, 2'd2, 32'h000012F0, 1'b1, 3'd3, 2'd0, 32'hFFFFFFF0}, // R4
        '{1'b0, 1'b0, 3'd0, 2'd2, 32'h00000000, 1'b1, 3'd3, 2'd1, 32'h000012F0}, // R4
        '{1'b1, 1'b1, 3'd3, 2'd0, 32'hFFFF007F, 1'b1, 3'd3, 2'd2, 32'h0000007F}, // R3
        '{1'b0, 1'b0, 3'd0, 2'd2, 32'h00000000, 1'b0, 3'd1, 2'd3, 32'hCAFEF00D}, // R5
        '{1'b1, 1'b1, 3'd4, 2'd3, 32'h80000001, 1'b1, 3'd4, 2'd1, 32'h00000001}  // R4
    };
    localparam string VTAG [NV] = '{"R5", "R1", "R1", "R5", "R2", "R2", "R3",
                                    "R3", "R3", "R4", "R4", "R3", "R5", "R4"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // One clock edge, then settle 1 ns past it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd0(input logic c, input logic [2:0] i, input logic [1:0] s);
        rd0_cls = c; rd0_idx = i; rd0_size = s; #0.1;
    endtask

    task automatic write(input logic c, input logic [2:0] i, input logic [1:0] s, input logic [31:0] d);
        wr_en = 1; wr_cls = c; wr_idx = i; wr_size = s; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state (R7)
        tick(); tick();
        rst_n = 1;
        tick();
        for (int i = 0; i < 8; i++) begin
            rd0(0, 3'(i), 2); check("R7 data reset", rd0_data, 0);
            rd0(1, 3'(i), 2); check("R7 addr reset", rd0_data, 0);
        end
        check("R7 load idle", {31'd0, ml_busy}, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            wr_en = VECS[v].wen; wr_cls = VECS[v].wcls; wr_idx = VECS[v].widx;
            wr_size = VECS[v].wsz; wr_data = VECS[v].wdat;
            rd0_cls = VECS[v].rcls; rd0_idx = VECS[v].ridx; rd0_size = VECS[v].rsz;
            tick();
            wr_en = 0;
            check(VTAG[v], rd0_data, VECS[v].exp);
        end

        // R9: read of the register being written shows the old value
        rd1_cls = 0; rd1_idx = 5; rd1_size = 2;
        wr_en = 1; wr_cls = 0; wr_idx = 5; wr_size = 2; wr_data = 32'hAAAA5555;
        #0.1;
        check("R9 pre-edge", rd1_data, 32'h0);
        tick();
        wr_en = 0;
        check("R9 post-edge", rd1_data, 32'hAAAA5555);

        // R6: stack pointer exchange on both mode edges
        rd1_cls = 1; rd1_idx = 7; rd1_size = 2;
        write(1, 7, 2, 32'h00001000);
        check("R6 sp write", rd1_data, 32'h00001000);
        super_mode = 1; tick();
        check("R6 rise swap", rd1_data, 32'h0);
        write(1, 7, 2, 32'h00002000);
        super_mode = 0; tick();
        check("R6 fall swap", rd1_data, 32'h00001000);
        tick();
        check("R6 stable level", rd1_data, 32'h00001000);
        super_mode = 1; tick();
        check("R6 rise again", rd1_data, 32'h00002000);

        // R11: write to A7 with a mode change in the same cycle
        super_mode = 0;
        write(1, 7, 2, 32'h00003000);
        check("R11 write wins", rd1_data, 32'h00003000);
        super_mode = 1; tick();
        check("R11 shadow old sp", rd1_data, 32'h00002000);

        // R8: long load D0, D2, A0, A7
        ml_start = 1; ml_mask = 16'h8105; ml_base = 32'h100; ml_size = 2;
        tick();
        ml_start = 0;
        check("R8 busy", {31'd0, ml_busy}, 1);
        check("R8 addr0", ml_addr, 32'h100);
        ml_rdata = 32'hD0D0D0D0; tick();
        check("R8 addr1", ml_addr, 32'h104);
        ml_rdata = 32'hD2D2D2D2; tick();
        check("R8 addr2", ml_addr, 32'h108);
        ml_rdata = 32'h80000001; tick();
        check("R8 addr3", ml_addr, 32'h10C);
        ml_rdata = 32'h0000ABCD; tick();
        check("R8 done", {31'd0, ml_busy}, 0);
        rd0(0, 0, 2); check("R8 D0", rd0_data, 32'hD0D0D0D0);
        rd0(0, 2, 2); check("R8 D2", rd0_data, 32'hD2D2D2D2);
        rd0(1, 0, 2); check("R8 A0", rd0_data, 32'h80000001);
        rd0(1, 7, 2); check("R8 A7", rd0_data, 32'h0000ABCD);
        rd0(0, 1, 2); check("R8 D1 untouched", rd0_data, 32'hCAFEF00D);

        // R8: word load D1 then A0, step 2
        ml_start = 1; ml_mask = 16'h0102; ml_base = 32'h200; ml_size = 1;
        tick();
        ml_start = 0;
        check("R8 word addr0", ml_addr, 32'h200);
        ml_rdata = 32'h00001234; tick();
        check("R8 word addr1", ml_addr, 32'h202);
        ml_rdata = 32'h0000F000; tick();
        check("R8 word done", {31'd0, ml_busy}, 0);
        rd0(0, 1, 2); check("R8 word D1 merge", rd0_data, 32'hCAFE1234);
        rd0(1, 0, 2); check("R8 word A0 sext", rd0_data, 32'hFFFFF000);

        // R8: zero mask starts nothing
        ml_start = 1; ml_mask = 16'h0000; ml_base = 32'h300;
        tick();
        ml_start = 0;
        check("R8 empty mask", {31'd0, ml_busy}, 0);

        // R10: write port and restart ignored while busy
        ml_start = 1; ml_mask = 16'h0010; ml_base = 32'h0; ml_size = 2;
        tick();
        ml_start = 1; ml_mask = 16'h0020; ml_base = 32'h900;
        wr_en = 1; wr_cls = 0; wr_idx = 6; wr_size = 2; wr_data = 32'h55;
        ml_rdata = 32'h77;
        tick();
        ml_start = 0; wr_en = 0;
        check("R10 no restart", {31'd0, ml_busy}, 0);
        rd0(0, 4, 2); check("R10 load data", rd0_data, 32'h77);
        rd0(0, 6, 2); check("R10 write ignored", rd0_data, 32'h0);
        rd0(0, 5, 2); check("R10 D5 unchanged", rd0_data, 32'hAAAA5555);

        // R7: second reset clears everything including the shadow
        rst_n = 0; tick(); tick();
        rst_n = 1; tick();
        rd0(0, 5, 2); check("R7 D5 cleared", rd0_data, 0);
        rd0(1, 7, 2); check("R7 A7 cleared", rd0_data, 0);
        check("R7 no swap after reset", rd1_data, 0);
        super_mode = 0; tick();
        rd0(1, 7, 2); check("R7 shadow cleared", rd0_data, 0);

        finish_run();
    end
endmodule